// File: doc/BRIEF.md
# Four-Channel Scatter Write Sequencer

The sequencer accepts one scatter-store command at a time and expands it into a stream of single-dword memory writes. A command carries a 64-bit base byte address, sixteen 64-bit per-lane byte offsets, a lane-count code, a four-bit colour-channel mask, a per-lane enable vector and a flat buffer of source dwords. The block walks the channels from red to alpha. Within each enabled channel it walks the lanes from 0 upward. It emits one write for every pair of an enabled channel and an enabled lane.

The channel's bit position sets the write address, so each channel index adds four bytes. The source data comes from a per-channel slot. Only enabled channels take a slot, and each slot is at least one register wide. Commands that cannot be executed are rejected with an error pulse. Writes that would land on a non-dword address are dropped with an error pulse, and the walk then carries on.

Top module: `scatter4_seq`

## Requirements
- R1: While reset is held and after it is released, cmd_ready is 1 and wr_valid, done and err are 0.
- R2: A cmd_size value of 3'b011 selects 8 lanes and 3'b100 selects 16 lanes. Lanes at or above that count never produce a write.
- R3: Writes are issued channel-major. Enabled channels are taken in the order bit 0 (R), bit 1 (G), bit 2 (B), bit 3 (A). Within a channel, enabled lanes are taken in ascending order.
- R4: The write address for channel bit c and lane i is cmd_base + offset[i] + 4*c. Here offset[i] is cmd_offsets[64*i +: 64], and c is the mask bit position, not the channel's rank among enabled channels.
- R5: The write data for lane i is source dword k*max(lanes, REG_BYTES/4) + i, taken from cmd_src[32*idx +: 32]. Here k is the number of enabled channels below the current one.
- R6: A lane whose cmd_lane_en bit is 0 produces no write, and it does not shift the source positions of later lanes or channels.
- R7: A command with an unsupported cmd_size or an all-zero cmd_chmask produces no write. In the cycle after it is accepted, done and err are both 1.
- R8: A write whose address has nonzero low two bits is not issued. err pulses once for it in the following cycle, and the remaining writes still go out.
- R9: While wr_valid is 1 and wr_ready is 0, wr_valid, wr_addr and wr_data hold their values into the next cycle.
- R10: cmd_ready is 0 from the acceptance of a legal command until its sequence has finished.
- R11: done is 1 for one cycle after the last write handshake or last skipped pair of a legal command. A legal command with no enabled lanes still produces done.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken when valid |
| cmd_size | input | 3 | Lane-count code |
| cmd_chmask | input | 4 | Channel enable mask, bit 0 = R |
| cmd_lane_en | input | MAX_LANES | Per-lane enable |
| cmd_base | input | AW | Base byte address |
| cmd_offsets | input | MAX_LANES*AW | Per-lane byte offsets, lane 0 in the low bits |
| cmd_src | input | SRC_DW*32 | Source dword buffer, dword 0 in the low bits |
| wr_valid | output | 1 | Write request present |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 32 | Write dword |
| done | output | 1 | Command finished pulse |
| err | output | 1 | Illegal command or misaligned write pulse |

## Verification
Several corner cases are driven on purpose. Sparse masks such as 4'b1010 and 4'b1000 catch a design that uses the channel rank in the address, which would shift every address down by a multiple of four bytes. Sixteen-lane commands catch slot sizing that ignores the lane count, which would read data from the wrong register. Gaps in the lane enable vector catch compaction of the source positions. Misaligned offsets mixed among good ones catch a design that halts or sends the bad write. Random backpressure catches outputs that change while a write is stalled. Illegal commands and a command with no enabled lanes catch a missing done or a stray write.

// File: rtl/scatter4_pkg.sv
package scatter4_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;

  localparam int NCH = 4;
  localparam int LCW = 5;

  function automatic logic [LCW-1:0] lanes_of(input logic [2:0] code);
    logic [LCW-1:0] n;
    case (code)
      3'b011:  n = LCW'(8);
      3'b100:  n = LCW'(16);
      default: n = '0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/s4_cmd_check.sv
module s4_cmd_check
  import scatter4_pkg::*;
#(
  parameter int MAX_LANES = 16
) (
  input  logic [2:0]     size_code,
  input  logic [NCH-1:0] chmask,
  output logic [LCW-1:0] lanes,
  output logic           legal
);

  logic [LCW-1:0] lanes_raw;

  always_comb begin
    lanes_raw = lanes_of(size_code);
    lanes     = lanes_raw;
    legal     = (lanes_raw != '0) && (lanes_raw <= LCW'(MAX_LANES)) && (chmask != '0);
  end

endmodule

// File: rtl/s4_cursor.sv
module s4_cursor
  import scatter4_pkg::*;
#(
  parameter int MAX_LANES = 16,
  localparam int LIW = $clog2(MAX_LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LCW-1:0]       lanes,
  input  logic [NCH-1:0]       chmask,
  input  logic [MAX_LANES-1:0] lane_en,
  input  logic                 hs,
  input  logic                 drop,
  output logic                 run,
  output logic [1:0]           ch,
  output logic [LIW-1:0]       lane,
  output logic [1:0]           chpos,
  output logic                 pair_on,
  output logic                 finish
);

  seq_state_e     state_q, state_d;
  logic [1:0]     ch_q, ch_d;
  logic [LIW-1:0] lane_q, lane_d;
  logic [1:0]     pos_q, pos_d;
  logic           advance, ch_on, last_lane, ch_done;

  always_comb begin
    ch_on     = chmask[ch_q];
    pair_on   = ch_on && lane_en[lane_q];
    last_lane = (LCW'(lane_q) + LCW'(1)) == lanes;
    ch_done   = !ch_on || last_lane;
    advance   = (state_q == ST_RUN) && (!pair_on || hs || drop);
    finish    = advance && ch_done && (ch_q == 2'd3);

    state_d = state_q;
    ch_d    = ch_q;
    lane_d  = lane_q;
    pos_d   = pos_q;
    if (start) begin
      state_d = ST_RUN;
      ch_d    = '0;
      lane_d  = '0;
      pos_d   = '0;
    end else if (advance) begin
      if (ch_done) begin
        ch_d   = ch_q + 2'd1;
        lane_d = '0;
        pos_d  = pos_q + {1'b0, ch_on};
        if (ch_q == 2'd3) state_d = ST_IDLE;
      end else begin
        lane_d = lane_q + LIW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      lane_q  <= '0;
      pos_q   <= '0;
    end else if (start || advance) begin
      state_q <= state_d;
      ch_q    <= ch_d;
      lane_q  <= lane_d;
      pos_q   <= pos_d;
    end
  end

  assign run   = (state_q == ST_RUN);
  assign ch    = ch_q;
  assign lane  = lane_q;
  assign chpos = pos_q;

  // R2: cursor never points past the lane count
  a_r2_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (LCW'(lane_q) < lanes));

  // R3: inside one channel lanes step upward by one
  a_r3_lane_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && advance && !ch_done) |=> (lane_q == $past(lane_q) + LIW'(1)) && (ch_q == $past(ch_q)));

endmodule

// File: rtl/s4_addr_gen.sv
module s4_addr_gen
  import scatter4_pkg::*;
#(
  parameter int MAX_LANES = 16,
  parameter int REG_BYTES = 32,
  parameter int AW        = 64,
  parameter int DW        = 32,
  localparam int LIW      = $clog2(MAX_LANES),
  localparam int RW       = REG_BYTES / 4,
  localparam int SLOTMAX  = (MAX_LANES > RW) ? MAX_LANES : RW,
  localparam int SRC_DW   = NCH * SLOTMAX,
  localparam int SIW      = $clog2(SRC_DW)
) (
  input  logic [AW-1:0]           base,
  input  logic [MAX_LANES*AW-1:0] offsets,
  input  logic [SRC_DW*DW-1:0]    src,
  input  logic [1:0]              ch,
  input  logic [LIW-1:0]          lane,
  input  logic [1:0]              chpos,
  input  logic [LCW-1:0]          lanes,
  output logic [AW-1:0]           addr,
  output logic [DW-1:0]           data,
  output logic                    misaligned
);

  logic [SIW-1:0] slot_w, idx;
  logic [AW-1:0]  lane_off;

  always_comb begin
    slot_w     = (SIW'(lanes) > SIW'(RW)) ? SIW'(lanes) : SIW'(RW);
    idx        = SIW'(chpos) * slot_w + SIW'(lane);
    lane_off   = offsets[lane*AW +: AW];
    addr       = base + lane_off + AW'({ch, 2'b00});
    data       = src[idx*DW +: DW];
    misaligned = |addr[1:0];
  end

endmodule

// File: rtl/scatter4_seq.sv
module scatter4_seq
  import scatter4_pkg::*;
#(
  parameter int MAX_LANES = 16,
  parameter int REG_BYTES = 32,
  parameter int AW        = 64,
  localparam int DW       = 32,
  localparam int LIW      = $clog2(MAX_LANES),
  localparam int RW       = REG_BYTES / 4,
  localparam int SLOTMAX  = (MAX_LANES > RW) ? MAX_LANES : RW,
  localparam int SRC_DW   = NCH * SLOTMAX
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [2:0]              cmd_size,
  input  logic [NCH-1:0]          cmd_chmask,
  input  logic [MAX_LANES-1:0]    cmd_lane_en,
  input  logic [AW-1:0]           cmd_base,
  input  logic [MAX_LANES*AW-1:0] cmd_offsets,
  input  logic [SRC_DW*DW-1:0]    cmd_src,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [AW-1:0]           wr_addr,
  output logic [DW-1:0]           wr_data,
  output logic                    done,
  output logic                    err
);

  logic [LCW-1:0]          lanes_in, lanes_q;
  logic                    legal;
  logic [NCH-1:0]          mask_q;
  logic [MAX_LANES-1:0]    en_q;
  logic [AW-1:0]           base_q;
  logic [MAX_LANES*AW-1:0] offs_q;
  logic [SRC_DW*DW-1:0]    src_q;

  logic           accept, start, hs, drop, run, pair_on, finish, misaligned;
  logic [1:0]     ch, chpos;
  logic [LIW-1:0] lane;
  logic           done_d, err_d, done_q, err_q;

  s4_cmd_check #(.MAX_LANES(MAX_LANES)) u_check (
    .size_code (cmd_size),
    .chmask    (cmd_chmask),
    .lanes     (lanes_in),
    .legal     (legal)
  );

  assign cmd_ready = !run;
  assign accept    = cmd_valid && cmd_ready;
  assign start     = accept && legal;

  always_ff @(posedge clk) begin
    if (start) begin
      lanes_q <= lanes_in;
      mask_q  <= cmd_chmask;
      en_q    <= cmd_lane_en;
      base_q  <= cmd_base;
      offs_q  <= cmd_offsets;
      src_q   <= cmd_src;
    end
  end

  s4_cursor #(.MAX_LANES(MAX_LANES)) u_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .lanes   (lanes_q),
    .chmask  (mask_q),
    .lane_en (en_q),
    .hs      (hs),
    .drop    (drop),
    .run     (run),
    .ch      (ch),
    .lane    (lane),
    .chpos   (chpos),
    .pair_on (pair_on),
    .finish  (finish)
  );

  s4_addr_gen #(
    .MAX_LANES (MAX_LANES),
    .REG_BYTES (REG_BYTES),
    .AW        (AW),
    .DW        (DW)
  ) u_addr (
    .base       (base_q),
    .offsets    (offs_q),
    .src        (src_q),
    .ch         (ch),
    .lane       (lane),
    .chpos      (chpos),
    .lanes      (lanes_q),
    .addr       (wr_addr),
    .data       (wr_data),
    .misaligned (misaligned)
  );

  assign wr_valid = run && pair_on && !misaligned;
  assign hs       = wr_valid && wr_ready;
  assign drop     = run && pair_on && misaligned;

  always_comb begin
    done_d = (accept && !legal) || finish;
    err_d  = (accept && !legal) || drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign done = done_q;
  assign err  = err_q;

  // R9: a stalled write keeps its request unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R8: no misaligned address ever reaches the write port
  a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00));

  // R10: no command taken while writes are outstanding
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !cmd_ready);

  // R7: rejected command reports at once and leaves the block idle
  a_r7_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !legal) |=> done && err && cmd_ready && !wr_valid);

  // R11: done never overlaps a pending write
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid);

endmodule

// File: tb/scatter4_seq_test.sv
module scatter4_seq_test;

  localparam int ML   = 16;
  localparam int AW   = 64;
  localparam int NSRC = 64;

  logic              clk, rst_n;
  logic              cmd_valid, cmd_ready;
  logic [2:0]        cmd_size;
  logic [3:0]        cmd_chmask;
  logic [ML-1:0]     cmd_lane_en;
  logic [AW-1:0]     cmd_base;
  logic [ML*AW-1:0]  cmd_offsets;
  logic [NSRC*32-1:0] cmd_src;
  logic              wr_valid, wr_ready;
  logic [AW-1:0]     wr_addr;
  logic [31:0]       wr_data;
  logic              done, err;

  scatter4_seq uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int done_cnt = 0, err_cnt = 0, wr_cnt = 0;
  int cycles = 0;
  bit stall = 0, busy = 0, prev_stall = 0;
  logic [AW-1:0] prev_addr;
  logic [31:0]   prev_data;
  logic [AW-1:0] q_addr[$];
  logic [31:0]   q_data[$];
  logic [AW-1:0] off_a[ML];
  logic [31:0]   src_a[NSRC];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // per-cycle comparison against the behavioural model queue
  always @(negedge clk) begin
    bit nr;
    if (rst_n) begin
      if (done) begin done_cnt++; busy = 0; end
      if (err) err_cnt++;
      if (busy) chk(cmd_ready == 1'b0, "R10", "cmd_ready while busy", cmd_ready, 0);
      if (prev_stall)
        chk(wr_valid && wr_addr == prev_addr && wr_data == prev_data, "R9",
            "stalled write changed", wr_addr, prev_addr);
      nr = stall ? (($urandom % 3) != 0) : 1'b1;
      wr_ready = nr;
      if (wr_valid && nr) begin
        wr_cnt++;
        if (q_addr.size() == 0) begin
          chk(0, "R3", "unexpected write", wr_addr, 0);
        end else begin
          chk(wr_addr == q_addr[0], "R4", "address", wr_addr, q_addr[0]);
          chk(wr_data == q_data[0], "R5", "data", wr_data, q_data[0]);
          void'(q_addr.pop_front());
          void'(q_data.pop_front());
        end
      end
      prev_stall = wr_valid && !nr;
      prev_addr  = wr_addr;
      prev_data  = wr_data;
    end
  end

  task automatic run_cmd(input logic [2:0] sz, input logic [3:0] mask,
                         input logic [ML-1:0] en, input logic [AW-1:0] base,
                         input bit stl, input string tag);
    int lanes, slot, pos, err_exp, d0, e0, n;
    bit legal;
    lanes = (sz == 3'b011) ? 8 : (sz == 3'b100) ? 16 : 0;
    legal = (lanes != 0) && (mask != 0);
    slot  = (lanes > 8) ? lanes : 8;
    pos = 0; err_exp = legal ? 0 : 1;
    if (legal) begin
      for (int c = 0; c < 4; c++) begin
        if (mask[c]) begin
          for (int i = 0; i < lanes; i++) begin
            if (en[i]) begin
              logic [AW-1:0] a;
              a = base + off_a[i] + AW'(4 * c);
              if (a[1:0] != 2'b00) err_exp++;
              else begin
                q_addr.push_back(a);
                q_data.push_back(src_a[pos * slot + i]);
              end
            end
          end
          pos++;
        end
      end
    end
    @(negedge clk); #1;
    for (int i = 0; i < ML; i++) cmd_offsets[i*AW +: AW] = off_a[i];
    for (int i = 0; i < NSRC; i++) cmd_src[i*32 +: 32] = src_a[i];
    cmd_size = sz; cmd_chmask = mask; cmd_lane_en = en; cmd_base = base;
    stall = stl;
    cmd_valid = 1'b1;
    d0 = done_cnt; e0 = err_cnt;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (legal) busy = 1;
    n = 0;
    while (done_cnt == d0 && n < 2000) begin
      @(negedge clk); #1;
      n++;
    end
    chk(done_cnt == d0 + 1, "R11", {tag, " done pulse"}, done_cnt - d0, 1);
    if (!legal) chk(n == 1 && err_cnt == e0 + 1, "R7", {tag, " reject timing"}, n, 1);
    chk(q_addr.size() == 0, "R3", {tag, " writes missing"}, q_addr.size(), 0);
    chk(err_cnt - e0 == err_exp, "R8", {tag, " err count"}, err_cnt - e0, err_exp);
    q_addr.delete(); q_data.delete();
    @(negedge clk); #1;
    chk(cmd_ready == 1'b1 && done == 1'b0, "R11", {tag, " idle after done"}, done, 0);
  endtask

  task automatic fill(input logic [AW-1:0] step, input int bad);
    for (int i = 0; i < ML; i++) off_a[i] = AW'(i) * step + {AW'($urandom) << 4, 4'h0};
    if (bad >= 0) off_a[bad] = off_a[bad] + 64'd2;
    for (int i = 0; i < NSRC; i++) src_a[i] = $urandom;
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; wr_ready = 1'b0;
    cmd_size = '0; cmd_chmask = '0; cmd_lane_en = '0; cmd_base = '0;
    cmd_offsets = '0; cmd_src = '0;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !wr_valid && !done && !err, "R1", "in reset", wr_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cmd_ready && !wr_valid && !done && !err, "R1", "after reset", wr_valid, 0);

    fill(64'h40, -1);
    run_cmd(3'b011, 4'b1111, 16'hFFFF, 64'h1000_0000, 0, "R2 8 lanes full");
    fill(64'h100, -1);
    run_cmd(3'b100, 4'b0101, 16'hA5F3, 64'h2000, 1, "R5 16 lanes sparse");
    fill(64'h8, -1);
    run_cmd(3'b011, 4'b1010, 16'hFF5A, 64'h7_0000_0000, 1, "R6 gaps");
    fill(64'h20, -1);
    run_cmd(3'b100, 4'b1000, 16'hFFFF, 64'h44, 1, "R4 alpha only");
    fill(64'h10, 5);
    run_cmd(3'b011, 4'b0011, 16'h00FF, 64'h800, 1, "R8 misaligned");
    run_cmd(3'b011, 4'b0000, 16'hFFFF, 64'h0, 0, "R7 empty mask");
    run_cmd(3'b101, 4'b1111, 16'hFFFF, 64'h0, 0, "R7 bad size");
    run_cmd(3'b011, 4'b1111, 16'h0000, 64'h0, 0, "R11 no lanes");
    fill(64'h4, -1);
    run_cmd(3'b100, 4'b1111, 16'hFFFF, 64'h3000, 1, "R3 16 lanes full");
    chk(wr_cnt > 0, "R3", "writes seen", wr_cnt, 1);
    finish_run();
  end

endmodule